// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block sequences one 10-bit successive-approximation conversion. It advances only on a single-cycle TAD enable tick, which is derived from the system clock. Software starts a conversion by setting a GO/DONE control bit. The sequencer first opens the hold-capacitor switch for one TAD period. It then resolves one bit per TAD, most significant bit first. For each step it drives a trial code to an external DAC and reads back a single-bit comparator decision.

At the end of the tenth bit, four things happen on the same edge:
- the result is packed into a 16-bit pair of result bytes, either right or left justified, with zero fill;
- GO/DONE drops;
- a completion flag is raised;
- the hold capacitor is reconnected.

Software can cancel a running conversion by writing GO/DONE low. The result bytes then keep their previous contents. The sequencer waits two TAD periods before acquisition resumes and GO/DONE can be accepted again. The result bytes can also be written by software at any time. When the converter is off, they serve as two general-purpose registers.

Top module: `sar_sequencer`

## Requirements
- R1: After reset, both result bytes are 0, GO/DONE reads 0, the completion flag is 0 and the hold capacitor is connected (holdConnect = 1).
- R2: A control write is accepted as a start only if three things hold: it sets GO/DONE with enable = 1, the converter was already enabled before that write, and the sequencer is idle. A single write that both enables the converter and sets GO/DONE does not start a conversion.
- R3: A conversion lasts 11 TAD ticks after the start. GO/DONE still reads 1 after the tenth tick and reads 0 after the eleventh.
- R4: holdConnect is 0 from the start until completion, and 1 again right after the completing tick.
- R5: After the first tick the DAC code is 10'h200. On each later tick the bit under trial is kept when cmpHigh = 1 (input at or above the DAC level) and cleared otherwise, and the next lower bit is set to 1. The final result therefore equals the input level seen by an ideal comparator.
- R6: With rightJust = 1, the high byte holds {6'b0, result[9:8]} and the low byte holds result[7:0].
- R7: With rightJust = 0, the high byte holds result[9:2] and the low byte holds {result[1:0], 6'b0}.
- R8: Completion sets irqFlag to 1. It stays 1 until an irqClear pulse, and is 0 after that.
- R9: A control write with GO/DONE = 0 (or enable = 0) during a conversion aborts it. GO/DONE reads 0 on the next cycle and both result bytes keep their previous values.
- R10: After an abort, holdConnect stays 0 and start requests are ignored for 2 TAD ticks. After the second tick, holdConnect is 1 and a start is accepted.
- R11: Software writes to either result byte take effect on the next cycle, whether the converter is disabled or converting. A completion overwrites both bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tadTick | input | 1 | One-cycle TAD period enable |
| cfgWe | input | 1 | Control register write strobe |
| cfgEn | input | 1 | Converter enable value written |
| cfgGo | input | 1 | GO/DONE value written |
| rightJust | input | 1 | 1 = right-justified result, 0 = left-justified |
| irqClear | input | 1 | Clears the completion flag |
| swWeHi | input | 1 | Software write to the high result byte |
| swWeLo | input | 1 | Software write to the low result byte |
| swData | input | 8 | Software write data |
| cmpHigh | input | 1 | Comparator: input at or above the DAC level |
| dacCode | output | 10 | Trial code for the DAC |
| holdConnect | output | 1 | 1 = hold capacitor connected to the input |
| goBusy | output | 1 | GO/DONE readback |
| irqFlag | output | 1 | Completion flag |
| resHi | output | 8 | High result byte |
| resLo | output | 8 | Low result byte |

## Verification
The hardest state to reach is the two-tick recovery window after an abort. The bench reaches it by preloading known bytes through the software path, starting a conversion and letting it run a few ticks. It then writes GO/DONE low, and issues start requests both before and between the two recovery ticks. Only after the second tick is a start expected to succeed. A second hard case is a software write that lands during a conversion: the bench checks that the write is seen at once and then replaced by the completed result.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int SAR_BITS = 10;
  localparam int BYTE_W   = 8;
  localparam int PAIR_W   = 2 * BYTE_W;
  localparam int PAD_W    = PAIR_W - SAR_BITS;
  localparam int IDX_W    = $clog2(SAR_BITS);

  typedef struct packed {
    logic             clearTrial;
    logic             seedMsb;
    logic             decide;
    logic [IDX_W-1:0] bitIdx;
    logic             loadResult;
  } sarStrobe_t;
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int RECOVER_TADS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tadTick,
  input  logic       cfgWe,
  input  logic       cfgEn,
  input  logic       cfgGo,
  input  logic       irqClear,
  output sarStrobe_t strb,
  output logic       goBusy,
  output logic       holdConnect,
  output logic       irqFlag
);
  localparam int REC_W = (RECOVER_TADS > 1) ? $clog2(RECOVER_TADS) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_SAMPLE, ST_CONV, ST_RECOVER} ctrlState_t;

  ctrlState_t       state;
  logic             enReg;
  logic             goBit;
  logic [IDX_W-1:0] bitIdx;
  logic [REC_W-1:0] recCnt;
  logic             converting;
  logic             goAccept;
  logic             abortReq;
  logic             finish;

  assign converting = (state == ST_SAMPLE) || (state == ST_CONV);
  assign goAccept   = cfgWe && cfgEn && cfgGo && enReg && (state == ST_IDLE) && !goBit;
  assign abortReq   = cfgWe && (!cfgGo || !cfgEn) && converting;
  assign finish     = tadTick && (state == ST_CONV) && (bitIdx == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitIdx <= '0;
      recCnt <= '0;
    end else if (abortReq) begin
      state  <= ST_RECOVER;
      recCnt <= '0;
    end else if (goAccept) begin
      state <= ST_SAMPLE;
    end else if (tadTick) begin
      case (state)
        ST_SAMPLE: begin
          state  <= ST_CONV;
          bitIdx <= IDX_W'(SAR_BITS - 1);
        end
        ST_CONV: begin
          if (bitIdx == '0) state <= ST_IDLE;
          else              bitIdx <= bitIdx - 1'b1;
        end
        ST_RECOVER: begin
          if (recCnt == REC_W'(RECOVER_TADS - 1)) state <= ST_IDLE;
          else                                    recCnt <= recCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg   <= 1'b0;
      goBit   <= 1'b0;
      irqFlag <= 1'b0;
    end else begin
      if (cfgWe) enReg <= cfgEn;
      if (abortReq || finish) goBit <= 1'b0;
      else if (goAccept)      goBit <= 1'b1;
      if (finish)        irqFlag <= 1'b1;
      else if (irqClear) irqFlag <= 1'b0;
    end
  end

  assign goBusy      = goBit;
  assign holdConnect = (state == ST_IDLE);

  always_comb begin
    strb.clearTrial = goAccept;
    strb.seedMsb    = tadTick && (state == ST_SAMPLE) && !abortReq;
    strb.decide     = tadTick && (state == ST_CONV) && !abortReq;
    strb.bitIdx     = bitIdx;
    strb.loadResult = finish && !abortReq;
  end

  // R3: GO/DONE only drops on a TAD tick or an abort write
  a_r3_go_falls_on_tick_or_abort: assert property (@(posedge clk) disable iff (!rstN)
    $fell(goBit) |-> ($past(tadTick) || $past(abortReq)));

  // R2: a start needs the converter enabled before the write
  a_r2_start_needs_prior_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(goBit) |-> $past(enReg));

  // R4: hold capacitor open while converting
  a_r4_hold_open_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    goBit |-> !holdConnect);

  // R10: no GO/DONE during recovery
  a_r10_no_go_in_recovery: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECOVER) |-> !goBit);

  // R8: flag rises together with GO/DONE falling
  a_r8_flag_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> (!goBit && $past(goBit)));
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  sarStrobe_t          strb,
  input  logic                cmpHigh,
  input  logic                rightJust,
  input  logic                swWeHi,
  input  logic                swWeLo,
  input  logic [BYTE_W-1:0]   swData,
  output logic [SAR_BITS-1:0] dacCode,
  output logic [BYTE_W-1:0]   resHi,
  output logic [BYTE_W-1:0]   resLo
);
  logic [SAR_BITS-1:0] trial;
  logic [SAR_BITS-1:0] finalCode;
  logic [PAIR_W-1:0]   pairWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trial <= '0;
    end else if (strb.clearTrial) begin
      trial <= '0;
    end else if (strb.seedMsb) begin
      trial <= SAR_BITS'(1) << (SAR_BITS - 1);
    end else if (strb.decide) begin
      trial[strb.bitIdx] <= cmpHigh;
      if (strb.bitIdx != '0) trial[strb.bitIdx - 1'b1] <= 1'b1;
    end
  end

  assign finalCode = {trial[SAR_BITS-1:1], cmpHigh};

  generate
    if (PAD_W > 0) begin : g_pad
      assign pairWord = rightJust ? {{PAD_W{1'b0}}, finalCode}
                                  : {finalCode, {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign pairWord = finalCode;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resHi <= '0;
      resLo <= '0;
    end else if (strb.loadResult) begin
      resHi <= pairWord[PAIR_W-1:BYTE_W];
      resLo <= pairWord[BYTE_W-1:0];
    end else begin
      if (swWeHi) resHi <= swData;
      if (swWeLo) resLo <= swData;
    end
  end

  assign dacCode = trial;

  // R5: first conversion tick seeds the MSB trial
  a_r5_msb_seed: assert property (@(posedge clk) disable iff (!rstN)
    strb.seedMsb |=> (dacCode == (SAR_BITS'(1) << (SAR_BITS - 1))));

  // R9/R11: result bytes only change on completion or software write
  a_r11_hi_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadResult && !swWeHi) |=> $stable(resHi));
  a_r11_lo_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadResult && !swWeLo) |=> $stable(resLo));
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_pkg::*;
#(
  parameter int RECOVER_TADS = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tadTick,
  input  logic                cfgWe,
  input  logic                cfgEn,
  input  logic                cfgGo,
  input  logic                rightJust,
  input  logic                irqClear,
  input  logic                swWeHi,
  input  logic                swWeLo,
  input  logic [BYTE_W-1:0]   swData,
  input  logic                cmpHigh,
  output logic [SAR_BITS-1:0] dacCode,
  output logic                holdConnect,
  output logic                goBusy,
  output logic                irqFlag,
  output logic [BYTE_W-1:0]   resHi,
  output logic [BYTE_W-1:0]   resLo
);
  sarStrobe_t strb;

  sar_ctrl #(.RECOVER_TADS(RECOVER_TADS)) u_ctrl (
    .clk(clk), .rstN(rstN), .tadTick(tadTick),
    .cfgWe(cfgWe), .cfgEn(cfgEn), .cfgGo(cfgGo), .irqClear(irqClear),
    .strb(strb), .goBusy(goBusy), .holdConnect(holdConnect), .irqFlag(irqFlag)
  );

  sar_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpHigh(cmpHigh),
    .rightJust(rightJust), .swWeHi(swWeHi), .swWeLo(swWeLo), .swData(swData),
    .dacCode(dacCode), .resHi(resHi), .resLo(resLo)
  );
endmodule

// File: tb/tb_sar_sequencer.sv
module tb_sar_sequencer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tadTick = 1'b0;
  logic       cfgWe = 1'b0, cfgEn = 1'b0, cfgGo = 1'b0;
  logic       rightJust = 1'b1;
  logic       irqClear = 1'b0;
  logic       swWeHi = 1'b0, swWeLo = 1'b0;
  logic [7:0] swData = '0;
  logic       cmpHigh;
  logic [9:0] dacCode;
  logic       holdConnect, goBusy, irqFlag;
  logic [7:0] resHi, resLo;
  logic [9:0] analogIn = '0;
  int         nChecks = 0;
  int         nFails = 0;
  bit         finished = 0;

  always #10 clk = ~clk;

  assign cmpHigh = (analogIn >= dacCode);

  sar_sequencer dut (
    .clk(clk), .rstN(rstN), .tadTick(tadTick), .cfgWe(cfgWe), .cfgEn(cfgEn),
    .cfgGo(cfgGo), .rightJust(rightJust), .irqClear(irqClear), .swWeHi(swWeHi),
    .swWeLo(swWeLo), .swData(swData), .cmpHigh(cmpHigh), .dacCode(dacCode),
    .holdConnect(holdConnect), .goBusy(goBusy), .irqFlag(irqFlag),
    .resHi(resHi), .resLo(resLo)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) tadTick = 1'b1;
    @(negedge clk) tadTick = 1'b0;
  endtask

  task automatic wrCfg(logic en, logic go);
    @(negedge clk) begin cfgWe = 1'b1; cfgEn = en; cfgGo = go; end
    @(negedge clk) cfgWe = 1'b0;
  endtask

  task automatic wrRes(logic hi, logic [7:0] d);
    @(negedge clk) begin swWeHi = hi; swWeLo = !hi; swData = d; end
    @(negedge clk) begin swWeHi = 1'b0; swWeLo = 1'b0; end
  endtask

  function automatic logic [15:0] packed16(logic [9:0] v, logic right);
    return right ? {6'b0, v} : {v, 6'b0};
  endfunction

  task automatic testReset();
    check("R1 resHi", resHi, 0);
    check("R1 resLo", resLo, 0);
    check("R1 goBusy", goBusy, 0);
    check("R1 irqFlag", irqFlag, 0);
    check("R1 holdConnect", holdConnect, 1);
  endtask

  task automatic testSwWhileOff();
    wrRes(1'b1, 8'h3C);
    wrRes(1'b0, 8'hE1);
    check("R11 sw hi while disabled", resHi, 8'h3C);
    check("R11 sw lo while disabled", resLo, 8'hE1);
  endtask

  task automatic testEnableAndGo();
    wrCfg(1'b1, 1'b1);
    check("R2 go with enable ignored", goBusy, 0);
    tick();
    check("R2 no conversion started", holdConnect, 1);
    check("R2 result untouched", resHi, 8'h3C);
  endtask

  task automatic runConv(logic [9:0] v, logic right, string req);
    logic [15:0] e;
    analogIn = v;
    rightJust = right;
    e = packed16(v, right);
    wrCfg(1'b1, 1'b1);
    check("R2 start accepted", goBusy, 1);
    check("R4 hold open after start", holdConnect, 0);
    tick();
    check("R5 msb seed", dacCode, 10'h200);
    repeat (9) tick();
    check("R3 busy after 10 ticks", goBusy, 1);
    tick();
    check("R3 done after 11 ticks", goBusy, 0);
    check("R4 hold reconnected", holdConnect, 1);
    check("R8 flag set", irqFlag, 1);
    check({req, " hi"}, resHi, e[15:8]);
    check({req, " lo"}, resLo, e[7:0]);
    @(negedge clk) irqClear = 1'b1;
    @(negedge clk) irqClear = 1'b0;
    check("R8 flag cleared", irqFlag, 0);
  endtask

  task automatic testAbort();
    wrRes(1'b1, 8'h5A);
    wrRes(1'b0, 8'hC3);
    analogIn = 10'h155;
    wrCfg(1'b1, 1'b1);
    repeat (4) tick();
    wrCfg(1'b1, 1'b0);
    check("R9 go cleared by abort", goBusy, 0);
    check("R9 hi kept", resHi, 8'h5A);
    check("R9 lo kept", resLo, 8'hC3);
    check("R10 hold open in recovery", holdConnect, 0);
    wrCfg(1'b1, 1'b1);
    check("R10 start ignored (0 ticks)", goBusy, 0);
    tick();
    wrCfg(1'b1, 1'b1);
    check("R10 start ignored (1 tick)", goBusy, 0);
    check("R10 hold still open", holdConnect, 0);
    tick();
    check("R10 hold reconnected", holdConnect, 1);
    check("R9 no flag after abort", irqFlag, 0);
    runConv(10'h155, 1'b1, "R10 conversion after recovery R6");
  endtask

  task automatic testSwDuringConv();
    analogIn = 10'h0F3;
    rightJust = 1'b1;
    wrCfg(1'b1, 1'b1);
    repeat (3) tick();
    wrRes(1'b1, 8'h77);
    check("R11 sw write during conversion", resHi, 8'h77);
    repeat (8) tick();
    check("R11 overwritten hi", resHi, 8'h00);
    check("R11 overwritten lo", resLo, 8'hF3);
    @(negedge clk) irqClear = 1'b1;
    @(negedge clk) irqClear = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSwWhileOff();
    testEnableAndGo();
    runConv(10'h2A5, 1'b1, "R6 right 2A5");
    runConv(10'h2A5, 1'b0, "R7 left 2A5");
    runConv(10'h000, 1'b1, "R5 zero");
    runConv(10'h3FF, 1'b0, "R5 full scale R7");
    runConv(10'h200, 1'b1, "R5 mid R6");
    testAbort();
    testSwDuringConv();
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule